// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a bank of on-chip peripheral lines and a few external pins. Each source can be masked on its own, and each carries one of eight priority levels. Among the unmasked pending sources, the one with the highest priority wins. If two winners share a level, the lower source number takes it. The winner raises a single normal request line to the processor, but only when its level is strictly above the level now being serviced. This is how nested servicing is allowed.

The processor talks to the block over a plain word-addressed register bus. Reading the acknowledge word returns the handler address that software stored for the winning source. The same read saves the current service level on an eight-deep stack and raises the level to that of the winner. A write to the end-of-service word restores the saved level. If nothing qualifies at the moment of the read, the read returns a programmable spurious address, so a request that vanished between the request line and the read does no harm.

Each source is either level-sensitive or rising-edge latched. External pins are first brought into the clock domain. A separate fast request input bypasses all of the priority logic and drives its own output.

Top module: `pvic_top`

## Requirements
- R1: After reset, irq_o and fiq_o are low, all enables are off, and the current level, stack depth and spurious vector are zero. The status word at address 0x86 reads as 0.
- R2: irq_o is high one clock after some enabled pending source of priority p has p+1 greater than the current level code, and is low otherwise. The level code is in status bits [3:0]: 0 when idle, k+1 while a source of priority k is being serviced.
- R3: Enable bit i controls source i. Writing ones to address 0x80 sets bits, writing ones to 0x81 clears bits, and 0x82 reads the mask back. A disabled source never raises irq_o and never wins an acknowledge.
- R4: The priority of source i is bits [2:0] of its configuration word at address 0x00+i, and 7 is the highest. The highest priority wins, and on a tie the lower source number wins. Peripheral lines are sources 0..N_PERIPH-1 and external pins follow them.
- R5: A read of 0x83 while a source qualifies returns the winner's vector, which is the word at 0x40+i. The same read pushes the current level, sets the level to the winner's priority+1, stores the winner's number in status bits [20:16] and increments the depth in status bits [11:8].
- R6: A read of 0x83 when no source qualifies returns the spurious vector held at address 0x85, and leaves the level and the depth unchanged.
- R7: A write to 0x84 pops the stack, restoring the previous level and decrementing the depth. At depth 0 such a write has no effect.
- R8: Configuration bit 4 set to 1 selects edge mode. A rising edge is then held pending until that source is acknowledged as the winner. With bit 4 at 0 the source follows its input, so a request withdrawn before the read gives the spurious vector.
- R9: While a source is being serviced, only a source of strictly higher priority raises irq_o and can be acknowledged. Up to eight nested acknowledges are held.
- R10: fiq_o follows fiq_i through two clock stages, gated by bit 0 of address 0x87. It does not depend on enables, priorities or the current level.
- R11: An external pin passes through a two-stage synchronizer, so irq_o rises at the third clock edge after the pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_irq_i | input | N_PERIPH | Synchronous peripheral request lines |
| ext_irq_i | input | N_EXT | Asynchronous external request pins |
| fiq_i | input | 1 | Fast request pin |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (side effects at address 0x83) |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the cycle of the strobe |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that the register bus never raises read and write in the same cycle, and that peripheral lines change only in step with the clock. The bench drives every bus access and every input change on the falling edge, and issues one access at a time. The acknowledge and stack assertions also assume that inputs hold steady between the request and the acknowledge read, except where a withdrawal is being tested. The random phase therefore fixes the input pattern for several cycles before each read. It uses only level mode, so the bench model can predict every winner from the pins.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int PRIO_W = 3;
  localparam int LVL_W  = PRIO_W + 1;
  localparam int AW     = 8;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [LVL_W-1:0]  lvl_t;

  typedef struct packed {
    logic  edge_md;
    prio_t prio;
  } src_cfg_t;

  localparam logic [AW-1:0] A_CFG_BASE = 8'h00;
  localparam logic [AW-1:0] A_VEC_BASE = 8'h40;
  localparam logic [AW-1:0] A_EN_SET   = 8'h80;
  localparam logic [AW-1:0] A_EN_CLR   = 8'h81;
  localparam logic [AW-1:0] A_EN_RD    = 8'h82;
  localparam logic [AW-1:0] A_ACK      = 8'h83;
  localparam logic [AW-1:0] A_EOI      = 8'h84;
  localparam logic [AW-1:0] A_SPUR     = 8'h85;
  localparam logic [AW-1:0] A_STAT     = 8'h86;
  localparam logic [AW-1:0] A_FEN      = 8'h87;

  // Level code of a source being serviced: priority + 1 (0 means idle).
  function automatic lvl_t prio_to_lvl(prio_t p);
    return lvl_t'({1'b0, p}) + lvl_t'(1);
  endfunction

  // A priority may interrupt only when strictly above the current level.
  function automatic logic outranks(prio_t p, lvl_t cur);
    return prio_to_lvl(p) > cur;
  endfunction
endpackage

// File: rtl/pvic_sense.sv
module pvic_sense #(
  parameter int SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic edge_md_i,
  input  logic ack_clr_i,
  output logic req_o
);
  logic seen;
  logic prev_q;
  logic lat_q;
  logic rise;

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q <= '0;
        end else begin
          sh_q[0] <= raw_i;
          for (int k = 1; k < SYNC_STAGES; k++) sh_q[k] <= sh_q[k-1];
        end
      end
      assign seen = sh_q[SYNC_STAGES-1];
    end else begin : g_direct
      assign seen = raw_i;
    end
  endgenerate

  assign rise = seen & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= seen;
      if (!edge_md_i)     lat_q <= 1'b0;
      else if (rise)      lat_q <= 1'b1;
      else if (ack_clr_i) lat_q <= 1'b0;
    end
  end

  assign req_o = edge_md_i ? lat_q : seen;

  AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_md_i && lat_q && !ack_clr_i) |=> (lat_q || !edge_md_i)); // R8
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter import pvic_pkg::*; #(
  parameter int NSRC = 16,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSRC-1:0]              req_i,
  input  logic [NSRC-1:0][PRIO_W-1:0]  prio_i,
  output logic                         win_valid_o,
  output logic [IDW-1:0]               win_id_o,
  output prio_t                        win_prio_o
);
  // Ascending scan that replaces only on a strictly higher priority:
  // the lowest index keeps a tie.
  always_comb begin
    win_valid_o = 1'b0;
    win_id_o    = '0;
    win_prio_o  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i] && (!win_valid_o || (prio_i[i] > win_prio_o))) begin
        win_valid_o = 1'b1;
        win_id_o    = IDW'(i);
        win_prio_o  = prio_i[i];
      end
    end
  end

  AST_WIN_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> req_i[win_id_o]); // R3
  AST_NO_REQ_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |-> !win_valid_o); // R4
endmodule

// File: rtl/pvic_nest_stack.sv
module pvic_nest_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  data_i,
  output logic [W-1:0]  top_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_m1;

  assign cnt_m1 = cnt_q - CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (push_i) begin
      cnt_q <= cnt_q + CW'(1);
    end else if (pop_i && (cnt_q != '0)) begin
      cnt_q <= cnt_m1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[cnt_q[IW-1:0]] <= data_i;
  end

  assign top_o = (cnt_q == '0) ? '0 : mem[cnt_m1[IW-1:0]];
  assign cnt_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q < CW'(DEPTH))); // R9
endmodule

// File: rtl/pvic_top.sv
module pvic_top import pvic_pkg::*; #(
  parameter int N_PERIPH   = 13,
  parameter int N_EXT      = 3,
  parameter int EXT_SYNC   = 2,
  parameter int DATA_W     = 32,
  parameter int NEST_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PERIPH-1:0] periph_irq_i,
  input  logic [N_EXT-1:0]    ext_irq_i,
  input  logic                fiq_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [AW-1:0]       bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                irq_o,
  output logic                fiq_o
);
  localparam int NSRC = N_PERIPH + N_EXT;
  localparam int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int CW   = $clog2(NEST_DEPTH + 1);

  src_cfg_t [NSRC-1:0]              cfg_q;
  logic     [NSRC-1:0][DATA_W-1:0]  vec_q;
  logic     [NSRC-1:0]              en_q;
  logic     [DATA_W-1:0]            spur_q;
  logic                             fen_q;
  lvl_t                             cur_lvl_q;
  logic     [IDW-1:0]               last_id_q;
  logic                             irq_q;
  logic     [1:0]                   fiq_s_q;

  logic [NSRC-1:0]             raw_src;
  logic [NSRC-1:0]             pend;
  logic [NSRC-1:0][PRIO_W-1:0] src_prio;
  logic                        win_valid;
  logic [IDW-1:0]              win_id;
  prio_t                       win_prio;
  lvl_t                        stk_top;
  logic [CW-1:0]               stk_cnt;

  // Named internal events
  logic hit, ack_rd, ack_take, spur_read, eoi_wr, eoi_pop;

  assign raw_src = {ext_irq_i, periph_irq_i};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    pvic_sense #(.SYNC_STAGES((i >= N_PERIPH) ? EXT_SYNC : 0)) u_sense (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_i     (raw_src[i]),
      .edge_md_i (cfg_q[i].edge_md),
      .ack_clr_i (ack_take && (win_id == IDW'(i))),
      .req_o     (pend[i])
    );
    assign src_prio[i] = cfg_q[i].prio;
  end

  pvic_arbiter #(.NSRC(NSRC)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (pend & en_q),
    .prio_i      (src_prio),
    .win_valid_o (win_valid),
    .win_id_o    (win_id),
    .win_prio_o  (win_prio)
  );

  assign hit       = win_valid && outranks(win_prio, cur_lvl_q);
  assign ack_rd    = bus_rd_i && (bus_addr_i == A_ACK);
  assign ack_take  = ack_rd && hit;
  assign spur_read = ack_rd && !hit;
  assign eoi_wr    = bus_wr_i && (bus_addr_i == A_EOI);
  assign eoi_pop   = eoi_wr && (stk_cnt != '0);

  pvic_nest_stack #(.DEPTH(NEST_DEPTH), .W(LVL_W)) u_stack (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (ack_take),
    .pop_i  (eoi_pop),
    .data_i (cur_lvl_q),
    .top_o  (stk_top),
    .cnt_o  (stk_cnt)
  );

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      vec_q  <= '0;
      en_q   <= '0;
      spur_q <= '0;
      fen_q  <= 1'b0;
    end else if (bus_wr_i) begin
      for (int i = 0; i < NSRC; i++) begin
        if (bus_addr_i == A_CFG_BASE + AW'(i)) begin
          cfg_q[i].edge_md <= bus_wdata_i[4];
          cfg_q[i].prio    <= bus_wdata_i[PRIO_W-1:0];
        end
        if (bus_addr_i == A_VEC_BASE + AW'(i)) vec_q[i] <= bus_wdata_i;
      end
      case (bus_addr_i)
        A_EN_SET: en_q   <= en_q | bus_wdata_i[NSRC-1:0];
        A_EN_CLR: en_q   <= en_q & ~bus_wdata_i[NSRC-1:0];
        A_SPUR:   spur_q <= bus_wdata_i;
        A_FEN:    fen_q  <= bus_wdata_i[0];
        default:  ;
      endcase
    end
  end

  // Service state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lvl_q <= '0;
      last_id_q <= '0;
      irq_q     <= 1'b0;
      fiq_s_q   <= '0;
    end else begin
      irq_q   <= hit && !ack_take;
      fiq_s_q <= {fiq_s_q[0], fiq_i};
      if (ack_take) begin
        cur_lvl_q <= prio_to_lvl(win_prio);
        last_id_q <= win_id;
      end else if (eoi_pop) begin
        cur_lvl_q <= stk_top;
      end
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_s_q[1] & fen_q;

  // Read path
  always_comb begin
    bus_rdata_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (bus_addr_i == A_CFG_BASE + AW'(i))
        bus_rdata_o = DATA_W'({cfg_q[i].edge_md, 1'b0, cfg_q[i].prio});
      if (bus_addr_i == A_VEC_BASE + AW'(i))
        bus_rdata_o = vec_q[i];
    end
    case (bus_addr_i)
      A_EN_RD: bus_rdata_o = DATA_W'(en_q);
      A_ACK:   bus_rdata_o = hit ? vec_q[win_id] : spur_q;
      A_SPUR:  bus_rdata_o = spur_q;
      A_FEN:   bus_rdata_o = DATA_W'(fen_q);
      A_STAT: begin
        bus_rdata_o[LVL_W-1:0] = cur_lvl_q;
        bus_rdata_o[8 +: CW]   = stk_cnt;
        bus_rdata_o[16 +: IDW] = last_id_q;
      end
      default: ;
    endcase
  end

  AST_ACK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (cur_lvl_q > $past(cur_lvl_q))); // R5
  AST_SPUR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    spur_read |=> ($stable(cur_lvl_q) && $stable(stk_cnt))); // R6
  AST_EOI_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pop |=> (cur_lvl_q < $past(cur_lvl_q))); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_q == '0) |-> !irq_o); // R3
  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_i && bus_wr_i)); // R5
endmodule

// File: tb/pvic_top_bench.sv
module pvic_top_bench;
  localparam int NP = 13;
  localparam int NE = 3;
  localparam int NS = NP + NE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NP-1:0] periph = '0;
  logic [NE-1:0] ext = '0;
  logic fiq_in = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, fiq;

  pvic_top u_pvic_top (
    .clk(clk), .rst_n(rst_n), .periph_irq_i(periph), .ext_irq_i(ext),
    .fiq_i(fiq_in), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  int total = 0, bad = 0;
  int m_prio [NS];
  logic [NS-1:0] m_en = '0;
  int m_lvl = 0, m_dep = 0;
  int m_stk [16];
  logic [31:0] m_spur = '0;

  function automatic logic [31:0] vec_of(int i);
    return 32'h1000_0000 + 32'(i) * 32'h40;
  endfunction

  // Expected winner from the requirements: best priority, lowest number on tie,
  // must be strictly above the current level; -1 when nothing qualifies.
  function automatic int exp_win(logic [NS-1:0] req);
    int best = -1;
    for (int i = 0; i < NS; i++)
      if (req[i] && m_en[i] && (best < 0 || m_prio[i] > m_prio[best])) best = i;
    if (best >= 0 && (m_prio[best] + 1) > m_lvl) return best;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic set_cfg(input int i, input int p, input logic edge_md);
    bus_write(8'(i), {27'b0, edge_md, 1'b0, 3'(p)});
    m_prio[i] = p;
  endtask

  task automatic en_set(input logic [NS-1:0] m);
    bus_write(8'h80, 32'(m));
    m_en = m_en | m;
  endtask

  task automatic en_clr(input logic [NS-1:0] m);
    bus_write(8'h81, 32'(m));
    m_en = m_en & ~m;
  endtask

  task automatic ack_chk(input string tag, input logic [NS-1:0] req);
    logic [31:0] v;
    int w;
    w = exp_win(req);
    bus_read(8'h83, v);
    if (w >= 0) begin
      chk(tag, v, vec_of(w));
      m_stk[m_dep] = m_lvl;
      m_dep++;
      m_lvl = m_prio[w] + 1;
    end else begin
      chk(tag, v, m_spur);
    end
  endtask

  task automatic eoi();
    bus_write(8'h84, 32'h0);
    if (m_dep > 0) begin
      m_dep--;
      m_lvl = m_stk[m_dep];
    end
  endtask

  task automatic stat_chk(input string tag);
    logic [31:0] v;
    bus_read(8'h86, v);
    chk(tag, 32'(v[3:0]), 32'(m_lvl));
    chk(tag, 32'(v[11:8]), 32'(m_dep));
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [NS-1:0] req;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NS; i++) m_prio[i] = 0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 fiq", 32'(fiq), 0);
    bus_read(8'h86, v); chk("R1 status", v, 0);
    bus_read(8'h82, v); chk("R1 enables", v, 0);
    ack_chk("R1 R6 spurious at reset", '0);

    bus_write(8'h85, 32'hDEAD_BEEF); m_spur = 32'hDEAD_BEEF;
    for (int i = 0; i < NS; i++) bus_write(8'h40 + 8'(i), vec_of(i));

    // R2 exact timing: level source, request registered one clock later
    set_cfg(2, 3, 1'b0);
    en_set(NS'(1) << 2);
    @(negedge clk); periph[2] = 1'b1;
    #1 chk("R2 irq before edge", 32'(irq), 0);
    @(negedge clk);
    chk("R2 irq after edge", 32'(irq), 1);
    ack_chk("R5 vector of src2", {ext, periph});
    bus_read(8'h86, v);
    chk("R5 level", 32'(v[3:0]), 4);
    chk("R5 depth", 32'(v[11:8]), 1);
    chk("R5 last id", 32'(v[20:16]), 2);

    // R9 nesting: equal blocked, higher allowed
    step(3);
    chk("R9 same level quiet", 32'(irq), 0);
    set_cfg(5, 3, 1'b0); en_set(NS'(1) << 5); periph[5] = 1'b1;
    step(3);
    chk("R9 equal priority quiet", 32'(irq), 0);
    set_cfg(7, 6, 1'b0); en_set(NS'(1) << 7); periph[7] = 1'b1;
    step(3);
    chk("R9 higher priority irq", 32'(irq), 1);
    ack_chk("R9 nested vector", {ext, periph});
    stat_chk("R9 nested status");
    eoi();
    stat_chk("R7 pop one");
    periph = '0;
    eoi();
    stat_chk("R7 pop to idle");
    eoi();
    stat_chk("R7 eoi when empty");

    // R3 masking
    set_cfg(9, 7, 1'b0);
    periph[9] = 1'b1;
    step(4);
    chk("R3 disabled quiet", 32'(irq), 0);
    ack_chk("R3 disabled gives spurious", {ext, periph});
    en_set(NS'(1) << 9);
    step(3);
    chk("R3 enabled irq", 32'(irq), 1);
    en_clr(NS'(1) << 9);
    step(3);
    chk("R3 cleared quiet", 32'(irq), 0);
    bus_read(8'h82, v); chk("R3 enable readback", v, 32'(m_en));
    periph = '0;

    // R4 tie and priority
    set_cfg(4, 5, 1'b0); set_cfg(11, 5, 1'b0);
    en_set((NS'(1) << 4) | (NS'(1) << 11));
    periph[4] = 1'b1; periph[11] = 1'b1;
    step(3);
    ack_chk("R4 tie lower number", {ext, periph});
    eoi();
    set_cfg(12, 6, 1'b0); en_set(NS'(1) << 12); periph[12] = 1'b1;
    step(3);
    ack_chk("R4 higher priority wins", {ext, periph});
    eoi();
    periph = '0;

    // R6 withdrawn level request
    periph[4] = 1'b1;
    step(3);
    chk("R6 irq raised", 32'(irq), 1);
    periph[4] = 1'b0;
    ack_chk("R6 R8 withdrawn gives spurious", {ext, periph});
    stat_chk("R6 state kept");

    // R8 edge mode
    set_cfg(3, 2, 1'b1); en_set(NS'(1) << 3);
    @(negedge clk); periph[3] = 1'b1;
    @(negedge clk); periph[3] = 1'b0;
    step(3);
    chk("R8 edge latched", 32'(irq), 1);
    ack_chk("R8 edge vector", NS'(1) << 3);
    eoi();
    step(3);
    chk("R8 cleared by ack", 32'(irq), 0);
    ack_chk("R8 no second service", '0);

    // R11 external synchronizer latency
    set_cfg(14, 4, 1'b0); en_set(NS'(1) << 14);
    @(negedge clk); ext[1] = 1'b1;
    @(negedge clk); chk("R11 edge1", 32'(irq), 0);
    @(negedge clk); chk("R11 edge2", 32'(irq), 0);
    @(negedge clk); chk("R11 edge3", 32'(irq), 1);
    ack_chk("R11 ext vector", {ext, periph});
    eoi();
    ext = '0;

    // R10 fast path
    fiq_in = 1'b1;
    step(4);
    chk("R10 gated off", 32'(fiq), 0);
    bus_write(8'h87, 32'h1);
    chk("R10 gated on", 32'(fiq), 1);
    en_clr('1);
    chk("R10 independent of enables", 32'(fiq), 1);
    @(negedge clk); fiq_in = 1'b0;
    @(negedge clk); chk("R10 stage delay", 32'(fiq), 1);
    @(negedge clk); chk("R10 released", 32'(fiq), 0);

    // Random phase, level mode only
    for (int it = 0; it < 200; it++) begin
      for (int k = 0; k < 3; k++) set_cfg(int'($urandom % NS), int'($urandom % 8), 1'b0);
      en_clr('1);
      en_set(NS'($urandom));
      periph = NP'($urandom);
      ext = NE'($urandom);
      step(4);
      req = {ext, periph};
      chk("R2 random irq", 32'(irq), 32'(exp_win(req) >= 0));
      ack_chk("R4 R5 random vector", req);
      if (($urandom % 3) != 0) eoi();
      if ((it % 8) == 0) stat_chk("R7 random status");
    end
    periph = '0; ext = '0;
    while (m_dep > 0) eoi();
    eoi();
    stat_chk("R7 drained");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule